// File: doc/BRIEF.md
# DMA Bus Tenure Throttle

This block sits between a DMA engine and the arbiter of a shared bus. It decides when the DMA engine may ask for the bus and when it must give the bus up. While it holds the bus, it counts completed transfers. It releases the bus once the programmed limit of transfers has been reached. It also releases early when the engine runs out of work, or, if that option is enabled, when another master asks for the bus. After every release it keeps its request low for a programmable dead time, so other masters get a fair window on the bus.

An optional watchdog covers two waits: the wait for a grant after raising the request, and the wait for each transfer acknowledge while the bus is held. If either wait runs past the limit, the block drops the bus, stops transfers and reports DMA timeout code 0x44. It holds that error until it is explicitly cleared.

Top module: `bus_tenure_throttle`

## Requirements
- R1: After reset `bus_req`, `xfer_en`, `xfer_size` and `tmo_err` are 0 and `err_code` is 0x00.
- R2: When idle with `xfer_req` high, `bus_req` rises, and `xfer_en` rises the cycle after `bus_gnt` is sampled high while requesting.
- R3: With `cfg_limit` = N (1..255), exactly N acknowledged transfers (`xfer_ack` sampled high while `xfer_en` is high) are allowed per tenure. `bus_req` and `xfer_en` are both low in the cycle right after the edge that samples the N-th acknowledge.
- R4: `cfg_limit` = 0 allows 256 transfers per tenure.
- R5: If `xfer_req` is sampled low while the bus is held, the bus is released on the next cycle, whatever the remaining count.
- R6: With `cfg_ror` = 1, `other_req` sampled high while the bus is held releases the bus on the next cycle. With `cfg_ror` = 0, `other_req` has no effect and the tenure runs to its limit.
- R7: After a release, `bus_req` stays low for D+1 cycles before the next request. D = 0, S, 2S or 4S for `cfg_dead` = 00, 01, 10, 11, and S = ceil(3.2 × CLK_MHZ) cycles (160 at 50 MHz).
- R8: `xfer_size` equals `cfg_long` while `xfer_en` is high and is 0 otherwise. Word and long-word transfers each count as one toward the limit.
- R9: With `cfg_tmo_en` = 1, if `bus_req` is high without a grant for TMO_CYCLES+1 cycles, the block raises `tmo_err`, sets `err_code` to 0x44 and drops `bus_req`.
- R10: With `cfg_tmo_en` = 1, if `xfer_en` is high without an acknowledge for TMO_CYCLES+1 cycles, the same timeout error is raised and `xfer_en` drops.
- R11: `tmo_err` and `err_code` hold, with `bus_req` and `xfer_en` low, until `err_clr` is sampled high. The next cycle `tmo_err` is 0 and `err_code` is 0x00.
- R12: With `cfg_tmo_en` = 0, no wait ever raises `tmo_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_limit | input | 8 | Maximum transfers per tenure, 0 means 256 |
| cfg_dead | input | 2 | Dead-time select after release |
| cfg_ror | input | 1 | Yield the bus when another master requests |
| cfg_long | input | 1 | Transfer size: 1 long word, 0 word |
| cfg_tmo_en | input | 1 | Enable the DMA timeout watchdog |
| xfer_req | input | 1 | DMA engine has pending transfers |
| xfer_ack | input | 1 | A transfer completed this cycle |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| other_req | input | 1 | Another master requests the bus |
| err_clr | input | 1 | Clears a latched timeout error |
| bus_req | output | 1 | Bus request to the arbiter |
| xfer_en | output | 1 | Engine may run transfers |
| xfer_size | output | 1 | Size of the enabled transfers |
| tmo_err | output | 1 | DMA timeout error latched |
| err_code | output | 8 | 0x44 on timeout, else 0x00 |

## Verification
The hardest situation to reach from the ports is the exact boundary of each counted window. This covers the 256th transfer when the limit field is zero, and the last cycle of the longest dead time. It also covers the cycle where the watchdog expires rather than one cycle early or late. To reach them, the bench drives the arbiter and the engine from the block's own outputs: the grant mirrors the request, and every enabled cycle carries an acknowledge. It then measures each window by counting cycles at the ports. The timeout limit is lowered by a parameter so that the grant wait and the acknowledge wait can both be held until they expire.

// File: rtl/bus_tenure_throttle.sv
module bus_tenure_throttle #(
  parameter int CLK_MHZ    = 50,
  parameter int TMO_CYCLES = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cfg_limit,
  input  logic [1:0] cfg_dead,
  input  logic       cfg_ror,
  input  logic       cfg_long,
  input  logic       cfg_tmo_en,
  input  logic       xfer_req,
  input  logic       xfer_ack,
  input  logic       bus_gnt,
  input  logic       other_req,
  input  logic       err_clr,
  output logic       bus_req,
  output logic       xfer_en,
  output logic       xfer_size,
  output logic       tmo_err,
  output logic [7:0] err_code
);

  localparam int STEP     = (32 * CLK_MHZ + 9) / 10;
  localparam int DEAD_MAX = 4 * STEP;
  localparam int DW       = $clog2(DEAD_MAX + 1);
  localparam int TW       = $clog2(TMO_CYCLES + 1);
  localparam logic [7:0] CODE_TMO = 8'h44;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_OWN, S_DEAD, S_ERR} st_t;

  st_t           st;
  logic [8:0]    left;
  logic [TW-1:0] timer;
  logic [DW-1:0] dead_cnt;
  logic [DW-1:0] dead_len;
  logic          expired, rel;

  always_comb begin
    case (cfg_dead)
      2'b00:   dead_len = '0;
      2'b01:   dead_len = DW'(STEP);
      2'b10:   dead_len = DW'(2 * STEP);
      default: dead_len = DW'(DEAD_MAX);
    endcase
  end

  assign expired = cfg_tmo_en && (timer == TW'(TMO_CYCLES));
  assign rel     = (xfer_ack && left == 9'd1) || (cfg_ror && other_req) || !xfer_req;

  assign bus_req   = (st == S_REQ) || (st == S_OWN);
  assign xfer_en   = (st == S_OWN);
  assign xfer_size = xfer_en & cfg_long;
  assign tmo_err   = (st == S_ERR);
  assign err_code  = tmo_err ? CODE_TMO : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      left     <= '0;
      timer    <= '0;
      dead_cnt <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          timer <= '0;
          if (xfer_req) st <= S_REQ;
        end
        S_REQ: begin
          if (bus_gnt) begin
            st    <= S_OWN;
            left  <= (cfg_limit == 8'd0) ? 9'd256 : {1'b0, cfg_limit};
            timer <= '0;
          end else if (expired) begin
            st <= S_ERR;
          end else if (cfg_tmo_en) begin
            timer <= timer + 1'b1;
          end
        end
        S_OWN: begin
          if (rel) begin
            timer <= '0;
            if (dead_len == '0) begin
              st <= S_IDLE;
            end else begin
              st       <= S_DEAD;
              dead_cnt <= dead_len - 1'b1;
            end
          end else if (xfer_ack) begin
            left  <= left - 1'b1;
            timer <= '0;
          end else if (expired) begin
            st <= S_ERR;
          end else if (cfg_tmo_en) begin
            timer <= timer + 1'b1;
          end
        end
        S_DEAD: begin
          if (dead_cnt == '0) st <= S_IDLE;
          else dead_cnt <= dead_cnt - 1'b1;
        end
        S_ERR: begin
          timer <= '0;
          if (err_clr) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module bus_tenure_throttle_props (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cfg_limit,
  input logic [1:0] cfg_dead,
  input logic       xfer_ack,
  input logic       err_clr,
  input logic       bus_req,
  input logic       xfer_en,
  input logic       tmo_err,
  input logic [7:0] err_code
);

  logic [8:0] acks;
  logic [8:0] cap;
  assign cap = (cfg_limit == 8'd0) ? 9'd256 : {1'b0, cfg_limit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                acks <= '0;
    else if (!xfer_en)         acks <= '0;
    else if (xfer_ack)         acks <= acks + 1'b1;
  end

  AST_WITHIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && xfer_ack) |-> (acks < cap)); // R3

  AST_EN_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_en |-> bus_req); // R2

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |-> (!bus_req && !xfer_en && err_code == 8'h44)); // R9

  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_err && !err_clr) |=> tmo_err); // R11

  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_err && err_clr) |=> (!tmo_err && err_code == 8'h00)); // R11

  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_req) && !tmo_err && cfg_dead != 2'b00 && $stable(cfg_dead)) |=> !bus_req); // R7

endmodule

bind bus_tenure_throttle bus_tenure_throttle_props u_props (
  .clk(clk), .rst_n(rst_n), .cfg_limit(cfg_limit), .cfg_dead(cfg_dead),
  .xfer_ack(xfer_ack), .err_clr(err_clr), .bus_req(bus_req),
  .xfer_en(xfer_en), .tmo_err(tmo_err), .err_code(err_code)
);

// File: tb/bus_tenure_throttle_test.sv
`timescale 1ns/1ps
module bus_tenure_throttle_test;

  localparam int TMO  = 40;
  localparam int MHZ  = 50;
  localparam int STEP = (32 * MHZ + 9) / 10;

  logic clk = 0, rst_n = 0;
  logic [7:0] cfg_limit = 8'd1;
  logic [1:0] cfg_dead = 2'b00;
  logic cfg_ror = 0, cfg_long = 0, cfg_tmo_en = 0;
  logic xfer_req = 0, xfer_ack = 0, bus_gnt = 0, other_req = 0, err_clr = 0;
  logic bus_req, xfer_en, xfer_size, tmo_err;
  logic [7:0] err_code;
  logic auto_gnt = 0;

  int vectors = 0, errors = 0;

  always #10 clk = ~clk;

  always @(negedge clk) bus_gnt <= auto_gnt ? bus_req : 1'b0;

  bus_tenure_throttle #(.CLK_MHZ(MHZ), .TMO_CYCLES(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_limit(cfg_limit), .cfg_dead(cfg_dead),
    .cfg_ror(cfg_ror), .cfg_long(cfg_long), .cfg_tmo_en(cfg_tmo_en),
    .xfer_req(xfer_req), .xfer_ack(xfer_ack), .bus_gnt(bus_gnt),
    .other_req(other_req), .err_clr(err_clr), .bus_req(bus_req),
    .xfer_en(xfer_en), .xfer_size(xfer_size), .tmo_err(tmo_err),
    .err_code(err_code)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_en();
    for (int i = 0; i < 2000 && !xfer_en; i++) cyc();
  endtask

  // run one tenure acking every enabled cycle; returns ack count and size errors
  task automatic tenure(output int n, output int size_bad);
    n = 0; size_bad = 0;
    xfer_req = 1; auto_gnt = 1;
    wait_en();
    for (int i = 0; i < 2000 && xfer_en; i++) begin
      if (xfer_size !== cfg_long) size_bad++;
      xfer_ack = 1; n++;
      cyc();
    end
    xfer_ack = 0;
  endtask

  initial begin
    #(20ns * 190000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int n, sb, exp_d;
    int lims[8] = '{1, 2, 3, 5, 17, 128, 255, 0};

    cyc(3);
    // R1 reset state
    chk("R1 bus_req", bus_req, 0);
    chk("R1 xfer_en", xfer_en, 0);
    chk("R1 xfer_size", xfer_size, 0);
    chk("R1 tmo_err", tmo_err, 0);
    chk("R1 err_code", err_code, 0);
    rst_n = 1;
    cyc(2);

    // R2 request and enable timing
    xfer_req = 1;
    cyc();
    chk("R2 bus_req rises", bus_req, 1);
    chk("R2 no enable before grant", xfer_en, 0);
    bus_gnt = 1; auto_gnt = 1;
    cyc();
    chk("R2 enable after grant", xfer_en, 1);
    xfer_req = 0;
    cyc();
    chk("R5 release when engine idle", bus_req, 0);
    cyc(5);

    // R3 R4 R8 limit sweep, both transfer sizes
    for (int l = 0; l < 8; l++) begin
      for (int sz = 0; sz < 2; sz++) begin
        cfg_limit = lims[l][7:0];
        cfg_long = sz[0];
        tenure(n, sb);
        chk(lims[l] == 0 ? "R4 limit zero gives 256" : "R3 transfers per tenure",
            n, lims[l] == 0 ? 256 : lims[l]);
        chk("R3 released after last ack", bus_req, 0);
        chk("R8 size follows cfg_long", sb, 0);
        xfer_req = 0;
        cyc(5);
        chk("R8 size low when disabled", xfer_size, 0);
      end
    end
    cfg_long = 0;

    // R5 engine runs out of work
    cfg_limit = 8'd10;
    xfer_req = 1;
    wait_en();
    for (int i = 0; i < 3; i++) begin xfer_ack = 1; cyc(); end
    xfer_ack = 0; xfer_req = 0;
    cyc();
    chk("R5 early release", xfer_en, 0);
    cyc(5);

    // R6 yield on other request
    cfg_ror = 1; cfg_limit = 8'd0;
    xfer_req = 1;
    wait_en();
    for (int i = 0; i < 5; i++) begin xfer_ack = 1; cyc(); end
    xfer_ack = 0; other_req = 1;
    cyc();
    chk("R6 yield releases enable", xfer_en, 0);
    chk("R6 yield releases request", bus_req, 0);
    other_req = 0; xfer_req = 0;
    cyc(5);
    cfg_ror = 0; cfg_limit = 8'd16; other_req = 1;
    tenure(n, sb);
    chk("R6 other_req ignored when disabled", n, 16);
    other_req = 0; xfer_req = 0;
    cyc(5);

    // R7 dead time sweep
    cfg_limit = 8'd1;
    for (int d = 0; d < 4; d++) begin
      cfg_dead = d[1:0];
      exp_d = (d == 0) ? 0 : (d == 1) ? STEP : (d == 2) ? 2 * STEP : 4 * STEP;
      tenure(n, sb);
      n = 0;
      for (int i = 0; i < 3000 && !bus_req; i++) begin n++; cyc(); end
      chk("R7 low cycles after release", n, exp_d + 1);
      xfer_req = 0;
      cyc(4 * STEP + 20);
    end
    cfg_dead = 2'b00;

    // R9 grant timeout
    cfg_tmo_en = 1; auto_gnt = 0;
    cyc(2);
    xfer_req = 1;
    cyc();
    n = 0;
    for (int i = 0; i < 1000 && bus_req; i++) begin n++; cyc(); end
    chk("R9 grant wait length", n, TMO + 1);
    chk("R9 error raised", tmo_err, 1);
    chk("R9 error code", err_code, 8'h44);

    // R11 hold and clear
    cyc(10);
    chk("R11 error held", tmo_err, 1);
    chk("R11 request stays low", bus_req, 0);
    xfer_req = 0; err_clr = 1;
    cyc();
    err_clr = 0;
    chk("R11 error cleared", tmo_err, 0);
    chk("R11 code cleared", err_code, 0);

    // R10 acknowledge timeout
    auto_gnt = 1; cfg_limit = 8'd4;
    xfer_req = 1;
    wait_en();
    n = 0;
    for (int i = 0; i < 1000 && xfer_en; i++) begin n++; cyc(); end
    chk("R10 ack wait length", n, TMO + 1);
    chk("R10 error raised", tmo_err, 1);
    xfer_req = 0; err_clr = 1;
    cyc();
    err_clr = 0;
    cyc(3);

    // R12 watchdog disabled
    cfg_tmo_en = 0; auto_gnt = 0;
    xfer_req = 1;
    cyc(3 * TMO);
    chk("R12 no error when disabled", tmo_err, 0);
    chk("R12 request still held", bus_req, 1);
    auto_gnt = 1;
    wait_en();
    cyc(3 * TMO);
    chk("R12 no ack timeout when disabled", tmo_err, 0);
    chk("R12 still enabled", xfer_en, 1);
    xfer_req = 0;
    cyc(5);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule